// File: doc/BRIEF.md
# Serial EEPROM Command Layer

This block is the command layer of a 512-byte serial EEPROM slave. A byte-level SPI front-end, which handles the bit shifting, clock polarity and the pause feature, hands it each received byte with a one-cycle strobe. It also tells the block whether the device is selected, synchronised to the system clock. The block decodes the first byte of each selection as an instruction and keeps a write-enable latch and a status register with two block-protect bits. It runs array reads, buffered array writes and status reads and writes against an internal 512x8 store.

For array operations the ninth address bit travels inside the instruction byte, so that one address byte completes the address. A write only collects bytes while the device is selected. The array update and a write-in-progress interval of fixed length, which stands in for the programming time, both start when the device is deselected. An unknown instruction makes the block ignore the rest of the selection.

For the front-end, `tx_data` holds the byte to shift out next and `tx_en` says whether the output should be driven. Both are valid from the cycle after a byte strobe until the next strobe.

Top module: `eecmd_core`

## Requirements
- R1: After reset the status byte reads 0xF0 (protect bits, latch and busy all clear), and every array location reads 0xFF.
- R2: Instruction bytes have bits 7..4 zero. Bits 2..0 select the operation: 110 sets the write-enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array. Bit 3 has no effect on the latch and status instructions.
- R3: After a set-latch or clear-latch instruction, all further bytes in the same selection are ignored and `tx_en` stays low.
- R4: An instruction byte outside the set in R2 makes the block ignore every later byte of that selection, with `tx_en` low.
- R5: An array read takes address bit 8 from bit 3 of the instruction and bits 7..0 from the next byte. It then returns one array byte per following byte slot, and the address increments and wraps from 0x1FF to 0x000.
- R6: A status read returns the status byte {1,1,1,1,BP1,BP0,WEL,BUSY} in every byte slot for as long as the device stays selected, and always shows the current values.
- R7: An array write takes its start address as in R5. The data bytes after the address fill a 16-byte page buffer, and the low four address bits wrap within that page. If the latch is set and at least one data byte arrived, deselecting writes the buffered bytes to the array and sets BUSY for WRITE_CYCLES cycles. If the latch is clear, nothing is written.
- R8: A committed array write or status write clears the write-enable latch, even when every byte falls in a protected region.
- R9: A status write with the latch set copies bits 3..2 of its data byte into BP1..BP0 at deselect and starts a BUSY interval. No other status bit can be written.
- R10: Protect bits 01 block addresses 0x180–0x1FF, 10 blocks 0x100–0x1FF and 11 blocks the whole array. Write bytes aimed at blocked addresses are discarded.
- R11: While `wp_n` is low, the write-enable latch is clear and set-latch instructions have no effect.
- R12: While BUSY is set, array read, array write and status write instructions are ignored for the rest of the selection (`tx_en` low), and status reads still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Device selected (synchronised, active high) |
| rx_valid | input | 1 | One-cycle strobe: a full byte has been received |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| wp_n | input | 1 | Write protect, active low |
| tx_data | output | 8 | Next byte for the front-end to shift out |
| tx_en | output | 1 | Front-end should drive its serial output |

## Verification
Two functions can fall in the same cycle: the end of a BUSY interval can meet a status read, and a latch clear forced by `wp_n` can meet a pending set-latch instruction. The bench issues a status read straight after a committed write. It checks that BUSY and a cleared latch show in the very first slot, and that a read attempted at the same time is refused. It then checks that BUSY is gone once the interval has elapsed. Lowering `wp_n` around set-latch instructions is judged by reading the latch back with a status read and by whether a later write reaches the array.

// File: rtl/eecmd_pkg.sv
package eecmd_pkg;

    localparam int ADDR_W    = 9;
    localparam int MEM_BYTES = 1 << ADDR_W;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RADDR,
        PH_RDATA,
        PH_WADDR,
        PH_WDATA,
        PH_SREAD,
        PH_SWR,
        PH_SDONE,
        PH_IGNORE
    } phase_t;

    typedef enum logic [2:0] {
        OP_SETWEL,
        OP_CLRWEL,
        OP_STRD,
        OP_STWR,
        OP_ARD,
        OP_AWR,
        OP_BAD
    } opkind_t;

    typedef struct packed {
        logic set_wel;
        logic clr_wel;
        logic wr_start;
        logic wr_byte;
        logic commit_wr;
        logic commit_sr;
    } evt_t;

    function automatic opkind_t decode_op(input logic [7:0] b);
        if (b[7:4] != 4'h0) return OP_BAD;
        case (b[2:0])
            3'b110:  return OP_SETWEL;
            3'b100:  return OP_CLRWEL;
            3'b101:  return OP_STRD;
            3'b001:  return OP_STWR;
            3'b011:  return OP_ARD;
            3'b010:  return OP_AWR;
            default: return OP_BAD;
        endcase
    endfunction

    function automatic logic is_protected(input logic [ADDR_W-1:0] a,
                                          input logic [1:0] bp);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] status_byte(input logic [1:0] bp,
                                               input logic wel,
                                               input logic wip);
        return {4'hF, bp, wel, wip};
    endfunction

endpackage

// File: rtl/eecmd_seq.sv
module eecmd_seq
    import eecmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              wip,
    output evt_t              evt,
    output phase_t            phase,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        sr_val
);

    phase_t nxt;
    logic   have_data;

    always_comb begin
        evt = '0;
        nxt = phase;
        if (!sel) begin
            nxt = PH_IDLE;
            if (phase == PH_WDATA && have_data) evt.commit_wr = 1'b1;
            if (phase == PH_SDONE)              evt.commit_sr = 1'b1;
        end else if (rx_valid) begin
            case (phase)
                PH_IDLE: begin
                    case (decode_op(rx_byte))
                        OP_SETWEL: begin evt.set_wel = 1'b1; nxt = PH_IGNORE; end
                        OP_CLRWEL: begin evt.clr_wel = 1'b1; nxt = PH_IGNORE; end
                        OP_STRD:   nxt = PH_SREAD;
                        OP_STWR:   nxt = wip ? PH_IGNORE : PH_SWR;
                        OP_ARD:    nxt = wip ? PH_IGNORE : PH_RADDR;
                        OP_AWR:    nxt = wip ? PH_IGNORE : PH_WADDR;
                        default:   nxt = PH_IGNORE;
                    endcase
                end
                PH_RADDR: nxt = PH_RDATA;
                PH_WADDR: begin nxt = PH_WDATA; evt.wr_start = 1'b1; end
                PH_WDATA: evt.wr_byte = 1'b1;
                PH_SWR:   nxt = PH_SDONE;
                default:  nxt = phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            addr      <= '0;
            sr_val    <= '0;
            have_data <= 1'b0;
        end else begin
            phase <= nxt;
            if (evt.wr_start || !sel)  have_data <= 1'b0;
            else if (evt.wr_byte)      have_data <= 1'b1;
            if (sel && rx_valid) begin
                case (phase)
                    PH_IDLE:            addr[ADDR_W-1] <= rx_byte[3];
                    PH_RADDR, PH_WADDR: addr[7:0]      <= rx_byte;
                    PH_RDATA:           addr           <= addr + 1'b1;
                    PH_SWR:             sr_val         <= rx_byte[3:2];
                    default: ;
                endcase
            end
        end
    end

    // R12
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rx_valid && phase == PH_IDLE && wip && rx_byte[7:4] == 4'h0
         && rx_byte[2:1] == 2'b01) |=> phase == PH_IGNORE);

    // R4
    bad_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rx_valid && phase == PH_IDLE && rx_byte[7:4] != 4'h0)
        |=> phase == PH_IGNORE);

    // R4
    ignore_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE && sel) |=> phase == PH_IGNORE);

endmodule

// File: rtl/eecmd_status.sv
module eecmd_status #(
    parameter int WRITE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wp_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       write_go,
    input  logic       sr_go,
    input  logic [1:0] sr_val,
    output logic       wel,
    output logic [1:0] bp,
    output logic       wip
);

    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
            bp  <= 2'b00;
            cnt <= '0;
        end else begin
            if (!wp_n || write_go || sr_go) wel <= 1'b0;
            else if (set_wel)               wel <= 1'b1;
            else if (clr_wel)               wel <= 1'b0;
            if (sr_go) bp <= sr_val;
            if (write_go || sr_go)  cnt <= CW'(WRITE_CYCLES);
            else if (cnt != '0)     cnt <= cnt - 1'b1;
        end
    end

    assign wip = (cnt != '0);

    // R8
    wel_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (write_go || sr_go) |=> !wel);

    // R11
    wp_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
        !wp_n |=> !wel);

    // R9
    bp_only_by_wrsr_chk: assert property (@(posedge clk) disable iff (rst)
        !sr_go |=> $stable(bp));

    // R7
    busy_starts_chk: assert property (@(posedge clk) disable iff (rst)
        write_go |=> wip);

    // R2
    set_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (set_wel && wp_n && !write_go && !sr_go) |=> wel);

endmodule

// File: rtl/eecmd_array.sv
module eecmd_array
    import eecmd_pkg::*;
#(
    parameter int PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_byte,
    input  logic [7:0]        wr_data,
    input  logic              write_go,
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - SLOT_W;

    logic [PG_W-1:0]       page_q;
    logic [SLOT_W-1:0]     slot_q;
    logic [7:0]            buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [PAGE_BYTES-1:0] slot_wr;
    logic [7:0]            mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            slot_q <= '0;
            vld_q  <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'h00;
        end else if (wr_start) begin
            page_q <= start_addr[ADDR_W-1:SLOT_W];
            slot_q <= start_addr[SLOT_W-1:0];
            vld_q  <= '0;
        end else if (wr_byte) begin
            buf_q[slot_q] <= wr_data;
            vld_q[slot_q] <= 1'b1;
            slot_q        <= slot_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        assign slot_wr[g] = vld_q[g] && !is_protected({page_q, SLOT_W'(g)}, bp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (write_go) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (slot_wr[i]) mem[{page_q, SLOT_W'(i)}] <= buf_q[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R7
    collect_commit_apart_chk: assert property (@(posedge clk) disable iff (rst)
        wr_byte |-> !write_go);

endmodule

// File: rtl/eecmd_core.sv
module eecmd_core
    import eecmd_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       wp_n,
    output logic [7:0] tx_data,
    output logic       tx_en
);

    evt_t              evt;
    phase_t            phase;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        sr_val;
    logic              wel;
    logic [1:0]        bp;
    logic              wip;
    logic              write_go;
    logic              sr_go;
    logic [7:0]        rd_data;

    eecmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .wip      (wip),
        .evt      (evt),
        .phase    (phase),
        .addr     (addr),
        .sr_val   (sr_val)
    );

    assign write_go = evt.commit_wr & wel;
    assign sr_go    = evt.commit_sr & wel;

    eecmd_status #(.WRITE_CYCLES(WRITE_CYCLES)) u_status (
        .clk      (clk),
        .rst      (rst),
        .wp_n     (wp_n),
        .set_wel  (evt.set_wel),
        .clr_wel  (evt.clr_wel),
        .write_go (write_go),
        .sr_go    (sr_go),
        .sr_val   (sr_val),
        .wel      (wel),
        .bp       (bp),
        .wip      (wip)
    );

    eecmd_array #(.PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk        (clk),
        .rst        (rst),
        .wr_start   (evt.wr_start),
        .start_addr ({addr[ADDR_W-1], rx_byte}),
        .wr_byte    (evt.wr_byte),
        .wr_data    (rx_byte),
        .write_go   (write_go),
        .bp         (bp),
        .rd_addr    (addr),
        .rd_data    (rd_data)
    );

    assign tx_en   = (phase == PH_RDATA) || (phase == PH_SREAD);
    assign tx_data = (phase == PH_RDATA) ? rd_data : status_byte(bp, wel, wip);

    // R3
    quiet_when_ignoring_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE) |-> !tx_en);

endmodule

// File: tb/eecmd_core_test.sv
module eecmd_core_test;

    localparam int WCYC = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       sel;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       wp_n;
    logic [7:0] tx_data;
    logic       tx_en;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_mem [512];
    logic [1:0] m_bp;
    logic       m_wel;

    always #5 clk = ~clk;

    eecmd_core #(.PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) uut (
        .clk(clk), .rst(rst), .sel(sel), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wp_n(wp_n), .tx_data(tx_data), .tx_en(tx_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit blocked(input int a, input logic [1:0] bp);
        if (bp == 2'b11) return 1;
        if (bp == 2'b10) return a >= 256;
        if (bp == 2'b01) return a >= 384;
        return 0;
    endfunction

    function automatic logic [7:0] exp_status(input bit busy);
        return {4'b1111, m_bp, m_wel, busy};
    endfunction

    task automatic sel_on();
        @(negedge clk);
        sel = 1'b1;
    endtask

    task automatic sel_off();
        @(negedge clk);
        sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r, output logic en);
        @(negedge clk);
        r = tx_data;
        en = tx_en;
        rx_byte = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_busy();
        repeat (WCYC + 4) @(negedge clk);
    endtask

    task automatic op_latch(input bit set, input bit b3);
        logic [7:0] r;
        logic en;
        sel_on();
        xfer({4'h0, b3, set ? 3'b110 : 3'b100}, r, en);
        sel_off();
        if (set) begin
            if (wp_n) m_wel = 1'b1;
        end else begin
            m_wel = 1'b0;
        end
    endtask

    task automatic op_status(input int n, input bit busy, input string req);
        logic [7:0] r;
        logic en;
        sel_on();
        xfer({4'h0, 1'($urandom_range(1)), 3'b101}, r, en);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r, en);
            chk(en && r == exp_status(busy), req, {en, r}, {1'b1, exp_status(busy)});
        end
        sel_off();
    endtask

    task automatic op_read(input int a, input int n, input string req);
        logic [7:0] r;
        logic en;
        sel_on();
        xfer({4'h0, a[8], 3'b011}, r, en);
        xfer(a[7:0], r, en);
        for (int k = 0; k < n; k++) begin
            int ea;
            ea = (a + k) % 512;
            xfer(8'($urandom), r, en);
            chk(en && r == m_mem[ea], req, {en, r}, {1'b1, m_mem[ea]});
        end
        sel_off();
    endtask

    task automatic op_write(input int a, input int n, input bit wait_after);
        logic [7:0] r;
        logic en;
        logic [7:0] bd [16];
        bit bv [16];
        for (int s = 0; s < 16; s++) bv[s] = 0;
        sel_on();
        xfer({4'h0, a[8], 3'b010}, r, en);
        xfer(a[7:0], r, en);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            int s;
            d = 8'($urandom);
            s = (a + k) % 16;
            bd[s] = d;
            bv[s] = 1;
            xfer(d, r, en);
        end
        sel_off();
        if (m_wel && n > 0) begin
            for (int s = 0; s < 16; s++) begin
                int ea;
                ea = (a & 9'h1F0) + s;
                if (bv[s] && !blocked(ea, m_bp)) m_mem[ea] = bd[s];
            end
            m_wel = 1'b0;
            if (wait_after) wait_busy();
        end
    endtask

    task automatic op_wrsr(input logic [7:0] v);
        logic [7:0] r;
        logic en;
        sel_on();
        xfer({4'h0, 1'($urandom_range(1)), 3'b001}, r, en);
        xfer(v, r, en);
        sel_off();
        if (m_wel) begin
            m_bp = v[3:2];
            m_wel = 1'b0;
            wait_busy();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic en;
        logic [7:0] r0;
        void'($urandom(32'd1234));
        sel = 0; rx_valid = 0; rx_byte = 0; wp_n = 1; rst = 1;
        m_bp = 0; m_wel = 0;
        for (int i = 0; i < 512; i++) m_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk(tx_en == 1'b0, "R1 idle output", tx_en, 0);
        op_status(1, 0, "R1 status after reset");
        op_read(9'h1A3, 2, "R1 erased array");

        // R2: bit 3 is don't-care for latch instructions
        op_latch(1, 1);
        op_status(1, 0, "R2 set latch with bit3=1");
        op_latch(0, 1);
        op_status(1, 0, "R2 clear latch with bit3=1");

        // R3: bytes after a set-latch instruction are ignored
        sel_on();
        xfer(8'h06, r, en);
        xfer(8'h04, r, en);
        xfer(8'h05, r, en);
        xfer(8'h00, r, en);
        chk(en == 1'b0, "R3 no output after latch instr", en, 0);
        sel_off();
        m_wel = 1'b1;
        op_status(1, 0, "R3 later clear ignored");

        // R4: invalid instruction then set-latch in same selection
        op_latch(0, 0);
        sel_on();
        xfer(8'h07, r, en);
        xfer(8'h06, r, en);
        xfer(8'h05, r, en);
        chk(en == 1'b0, "R4 output off after bad opcode", en, 0);
        sel_off();
        sel_on();
        xfer(8'h46, r, en);
        xfer(8'h06, r, en);
        sel_off();
        op_status(1, 0, "R4 latch untouched");

        // R7: write without latch is discarded
        op_write(9'h010, 3, 1);
        op_read(9'h010, 3, "R7 no write without latch");

        // R7/R8/R12: page wrap, busy, refused read during busy
        op_latch(1, 0);
        op_write(9'h1FE, 3, 0);
        op_status(2, 1, "R8 R12 busy and latch clear just after write");
        sel_on();
        xfer(8'h03, r, en);
        xfer(8'h00, r, en);
        xfer(8'h00, r, en);
        chk(en == 1'b0, "R12 read refused while busy", en, 0);
        sel_off();
        wait_busy();
        op_status(1, 0, "R7 busy ends");
        op_read(9'h1F0, 1, "R7 page wrap to slot 0");
        op_read(9'h1FE, 2, "R7 page bytes stored");

        // R5: read wrap across top of array
        op_read(9'h1FE, 4, "R5 address wrap 1FF to 000");

        // R6: repeated status bytes
        op_latch(1, 0);
        op_status(3, 0, "R6 repeated status");

        // R9/R10/R8: protect all, write discarded, latch cleared
        op_wrsr(8'hFF);
        op_status(1, 0, "R9 protect bits only");
        op_latch(1, 0);
        op_write(9'h020, 2, 1);
        op_status(1, 0, "R8 latch cleared on protected write");
        op_read(9'h020, 2, "R10 all protected");

        // R10: upper quarter boundary
        op_latch(1, 0);
        op_wrsr(8'h04);
        op_latch(1, 0);
        op_write(9'h17F, 2, 1);
        op_read(9'h17F, 2, "R10 quarter boundary");
        op_latch(1, 0);
        op_wrsr(8'h08);
        op_latch(1, 0);
        op_write(9'h0FF, 2, 1);
        op_read(9'h0FF, 2, "R10 half boundary");

        // R11: write protect pin
        op_latch(1, 0);
        @(negedge clk);
        wp_n = 1'b0;
        m_wel = 1'b0;
        @(negedge clk);
        op_status(1, 0, "R11 pin low clears latch");
        op_latch(1, 0);
        op_status(1, 0, "R11 set ignored while pin low");
        r0 = m_mem[9'h005];
        op_write(9'h005, 1, 1);
        op_read(9'h005, 1, "R11 write blocked");
        chk(m_mem[9'h005] == r0, "R11 model unchanged", m_mem[9'h005], r0);
        wp_n = 1'b1;

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int sel_op;
            sel_op = $urandom_range(9);
            case (sel_op)
                0, 1: op_latch(1, 1'($urandom_range(1)));
                2:    op_latch(0, 1'($urandom_range(1)));
                3:    op_status($urandom_range(1, 3), 0, "R6 random status");
                4, 5: op_write($urandom_range(511), $urandom_range(0, 20), 1);
                6, 7: op_read($urandom_range(511), $urandom_range(1, 6), "R5 random read");
                8:    op_wrsr(8'($urandom));
                default: begin
                    @(negedge clk);
                    wp_n = ($urandom_range(3) != 0);
                    if (!wp_n) m_wel = 1'b0;
                    @(negedge clk);
                end
            endcase
        end
        wp_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule